// File: doc/BRIEF.md
# Virtual Interrupt Interface Control Register Bank

This block keeps the control state of one virtual interrupt CPU interface: a priority mask, a binary point for each interrupt group, an end-of-interrupt mode, a common-binary-point mode and two group enables. The state can be reached through two synchronous register ports that share one store. The hypervisor port moves the whole state as one packed 32-bit word, which is how a hypervisor saves and restores a guest's view. The guest port splits the same state into small registers that each hold one field.

The block applies the binary point floors and keeps the reserved bits at zero. It also implements common-binary-point mode. In that mode the group 1 binary point seen by the guest is derived from the group 0 value, and guest writes to it are dropped. It exports the mask, the effective binary points, the enables and the mode bits that steer prioritisation and end-of-interrupt handling elsewhere.

Each cycle, a small write-source selector picks exactly one of three named states. WS_IDLE means no write lands. WS_HYP means the packed word is written. WS_GUEST means an accepted guest register write lands. The selector goes to WS_HYP whenever the hypervisor write enable is high. It goes to WS_GUEST when only an accepted guest write is present, and to WS_IDLE otherwise. The store holds its value in WS_IDLE and applies the chosen write in the other two states.

Top module: `vif_ctrl_bank`

## Requirements
- R1: After reset, the mask is 0, both enables are 0, EOI mode is 0 and common binary point is 0. Binary point 0 is 2 and binary point 1 is 3, so the packed word reads 0x004C0008.
- R2: The packed word keeps fixed field positions. The mask is in bits 31:24, binary point 0 in 23:21 and binary point 1 in 20:18. EOI mode is bit 9, common binary point is bit 4, group 1 enable is bit 1 and group 0 enable is bit 0. Bit 3 always reads 1. Bits 17:10, 8:5 and 2 always read 0.
- R3: A packed write loads every field from its position. Writes to bit 3 and to the reserved bits have no effect.
- R4: Binary point 0 never holds less than 2. A write below 2 from either port stores 2.
- R5: Binary point 1 never holds less than 3. A write below 3 from either port stores 3.
- R6: The guest register map uses these addresses. 0 is the mask (bits 7:0). 1 is binary point 0 and 2 is binary point 1 (bits 2:0 each). 3 is control, with EOI mode in bit 0 and common binary point in bit 1. 4 is the group 0 enable and 5 is the group 1 enable (bit 0 each). Unused bits read 0. Addresses 6 and 7 read 0, and writes to them change nothing.
- R7: While common binary point is 1, guest address 2 reads as binary point 0 plus one, saturated at 7. Guest writes to address 2 are dropped and leave the stored field unchanged. The effective group 1 output follows the derived value.
- R8: While common binary point is 0, the two binary points are independent. The effective outputs equal the stored values, and writing one does not move the other.
- R9: A write through either port is visible through the other port on the next read.
- R10: If both ports write in the same cycle, only the hypervisor write takes effect.
- R11: Read data on both ports is registered. It appears one cycle after the address is presented and reflects every write completed before that cycle.
- R12: The mask, group enables, EOI mode and common binary point outputs follow the stored state one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_we | input | 1 | Hypervisor packed word write enable |
| hv_wdata | input | 32 | Hypervisor packed write data |
| hv_rdata | output | 32 | Hypervisor packed read data, registered |
| gst_addr | input | 3 | Guest register address |
| gst_we | input | 1 | Guest register write enable |
| gst_wdata | input | 32 | Guest register write data |
| gst_rdata | output | 32 | Guest register read data, registered |
| prio_mask_o | output | 8 | Current priority mask |
| eff_bp0_o | output | 3 | Effective group 0 binary point |
| eff_bp1_o | output | 3 | Effective group 1 binary point |
| grp0_en_o | output | 1 | Group 0 enable |
| grp1_en_o | output | 1 | Group 1 enable |
| eoi_split_o | output | 1 | EOI mode: 1 means the end-of-interrupt write only drops priority |
| common_bp_o | output | 1 | Common binary point mode |

## Verification
The properties assume that the write enables, the guest address and both write data buses are known values whenever reset is inactive. They also assume each input holds its value for a whole clock cycle. Several properties key on a guest write with no hypervisor write in the same cycle, so they rely on both enables being sampled together at one edge. The stimulus changes every input only on the falling clock edge and always drives a defined value, including during reset, so these assumptions hold throughout.

// File: rtl/vif_pkg.sv
package vif_pkg;

    localparam int WORD_W  = 32;
    localparam int PRIO_W  = 8;
    localparam int BP_W    = 3;
    localparam int GADDR_W = 3;

    // packed save/restore word field positions
    localparam int PM_LO    = 24;
    localparam int BP0_LO   = 21;
    localparam int BP1_LO   = 18;
    localparam int EOIM_BIT = 9;
    localparam int CBPR_BIT = 4;
    localparam int FIQ_BIT  = 3;
    localparam int EN1_BIT  = 1;
    localparam int EN0_BIT  = 0;

    typedef struct packed {
        logic [PRIO_W-1:0] pmask;
        logic [BP_W-1:0]   bp0;
        logic [BP_W-1:0]   bp1;
        logic              eoim;
        logic              cbpr;
        logic              en1;
        logic              en0;
    } vif_state_t;

    typedef enum logic [GADDR_W-1:0] {
        GREG_PMASK = 3'd0,
        GREG_BP0   = 3'd1,
        GREG_BP1   = 3'd2,
        GREG_CTRL  = 3'd3,
        GREG_EN0   = 3'd4,
        GREG_EN1   = 3'd5
    } greg_e;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_HYP   = 2'd1,
        WS_GUEST = 2'd2
    } wsrc_e;

    function automatic logic [BP_W-1:0] bp_floor(input logic [BP_W-1:0] v,
                                                 input logic [BP_W-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic logic [BP_W-1:0] bp_inc_sat(input logic [BP_W-1:0] v);
        return (v == {BP_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    function automatic logic [WORD_W-1:0] pack_state(input vif_state_t s);
        logic [WORD_W-1:0] w;
        w = '0;
        w[PM_LO  +: PRIO_W] = s.pmask;
        w[BP0_LO +: BP_W]   = s.bp0;
        w[BP1_LO +: BP_W]   = s.bp1;
        w[EOIM_BIT]         = s.eoim;
        w[CBPR_BIT]         = s.cbpr;
        w[FIQ_BIT]          = 1'b1;
        w[EN1_BIT]          = s.en1;
        w[EN0_BIT]          = s.en0;
        return w;
    endfunction

    function automatic logic is_mapped(input logic [GADDR_W-1:0] a);
        return a <= GADDR_W'(GREG_EN1);
    endfunction

endpackage

// File: rtl/vif_wr_arbiter.sv
module vif_wr_arbiter
    import vif_pkg::*;
(
    input  logic               hv_we,
    input  logic               gst_we,
    input  logic [GADDR_W-1:0] gst_addr,
    input  logic               common_bp,
    output wsrc_e              src
);

    logic guest_ok;

    // a guest write is accepted only to a mapped register, and never to the
    // group 1 binary point while it is derived from group 0
    always_comb begin
        guest_ok = gst_we && is_mapped(gst_addr)
                   && !((gst_addr == GADDR_W'(GREG_BP1)) && common_bp);
    end

    always_comb begin
        unique casez ({hv_we, guest_ok})
            2'b1?:   src = WS_HYP;
            2'b01:   src = WS_GUEST;
            default: src = WS_IDLE;
        endcase
    end

endmodule

// File: rtl/vif_state_store.sv
module vif_state_store
    import vif_pkg::*;
#(
    parameter int BP0_MIN = 2,
    parameter int BP1_MIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wsrc_e              src,
    input  logic [WORD_W-1:0]  hv_wdata,
    input  logic [GADDR_W-1:0] gst_addr,
    input  logic [WORD_W-1:0]  gst_wdata,
    output vif_state_t         st_q
);

    localparam logic [BP_W-1:0] LO0 = BP_W'(BP0_MIN);
    localparam logic [BP_W-1:0] LO1 = BP_W'(BP1_MIN);

    vif_state_t st_d;

    // bits of the buses the store never looks at
    logic unused_bits;
    assign unused_bits = ^{hv_wdata[17:10], hv_wdata[8:5], hv_wdata[3:2],
                           gst_wdata[WORD_W-1:PRIO_W]};

    always_comb begin
        st_d = st_q;
        unique case (src)
            WS_HYP: begin
                st_d.pmask = hv_wdata[PM_LO +: PRIO_W];
                st_d.bp0   = bp_floor(hv_wdata[BP0_LO +: BP_W], LO0);
                st_d.bp1   = bp_floor(hv_wdata[BP1_LO +: BP_W], LO1);
                st_d.eoim  = hv_wdata[EOIM_BIT];
                st_d.cbpr  = hv_wdata[CBPR_BIT];
                st_d.en1   = hv_wdata[EN1_BIT];
                st_d.en0   = hv_wdata[EN0_BIT];
            end
            WS_GUEST: begin
                case (gst_addr)
                    GADDR_W'(GREG_PMASK): st_d.pmask = gst_wdata[PRIO_W-1:0];
                    GADDR_W'(GREG_BP0):   st_d.bp0   = bp_floor(gst_wdata[BP_W-1:0], LO0);
                    GADDR_W'(GREG_BP1):   st_d.bp1   = bp_floor(gst_wdata[BP_W-1:0], LO1);
                    GADDR_W'(GREG_CTRL): begin
                        st_d.eoim = gst_wdata[0];
                        st_d.cbpr = gst_wdata[1];
                    end
                    GADDR_W'(GREG_EN0):   st_d.en0 = gst_wdata[0];
                    GADDR_W'(GREG_EN1):   st_d.en1 = gst_wdata[0];
                    default: ;
                endcase
            end
            WS_IDLE: ;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pmask <= '0;
            st_q.bp0   <= LO0;
            st_q.bp1   <= LO1;
            st_q.eoim  <= 1'b0;
            st_q.cbpr  <= 1'b0;
            st_q.en1   <= 1'b0;
            st_q.en0   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vif_guest_read.sv
module vif_guest_read
    import vif_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  vif_state_t         st,
    input  logic [BP_W-1:0]    eff_bp1,
    input  logic [GADDR_W-1:0] gst_addr,
    output logic [WORD_W-1:0]  gst_rdata
);

    logic [WORD_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        case (gst_addr)
            GADDR_W'(GREG_PMASK): rd_d[PRIO_W-1:0] = st.pmask;
            GADDR_W'(GREG_BP0):   rd_d[BP_W-1:0]   = st.bp0;
            GADDR_W'(GREG_BP1):   rd_d[BP_W-1:0]   = eff_bp1;
            GADDR_W'(GREG_CTRL):  rd_d[1:0]        = {st.cbpr, st.eoim};
            GADDR_W'(GREG_EN0):   rd_d[0]          = st.en0;
            GADDR_W'(GREG_EN1):   rd_d[0]          = st.en1;
            default:              rd_d             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gst_rdata <= '0;
        else        gst_rdata <= rd_d;
    end

endmodule

// File: rtl/vif_ctrl_bank.sv
module vif_ctrl_bank
    import vif_pkg::*;
#(
    parameter int BP0_MIN = 2,
    parameter int BP1_MIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hv_we,
    input  logic [WORD_W-1:0]  hv_wdata,
    output logic [WORD_W-1:0]  hv_rdata,
    input  logic [GADDR_W-1:0] gst_addr,
    input  logic               gst_we,
    input  logic [WORD_W-1:0]  gst_wdata,
    output logic [WORD_W-1:0]  gst_rdata,
    output logic [PRIO_W-1:0]  prio_mask_o,
    output logic [BP_W-1:0]    eff_bp0_o,
    output logic [BP_W-1:0]    eff_bp1_o,
    output logic               grp0_en_o,
    output logic               grp1_en_o,
    output logic               eoi_split_o,
    output logic               common_bp_o
);

    localparam vif_state_t RST_STATE = '{
        pmask: '0, bp0: BP_W'(BP0_MIN), bp1: BP_W'(BP1_MIN),
        eoim: 1'b0, cbpr: 1'b0, en1: 1'b0, en0: 1'b0
    };

    wsrc_e           wsrc;
    vif_state_t      st_q;
    logic [BP_W-1:0] bp1_derived;
    logic [BP_W-1:0] bp1_stored;

    vif_wr_arbiter u_arb (
        .hv_we     (hv_we),
        .gst_we    (gst_we),
        .gst_addr  (gst_addr),
        .common_bp (st_q.cbpr),
        .src       (wsrc)
    );

    vif_state_store #(
        .BP0_MIN (BP0_MIN),
        .BP1_MIN (BP1_MIN)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .src       (wsrc),
        .hv_wdata  (hv_wdata),
        .gst_addr  (gst_addr),
        .gst_wdata (gst_wdata),
        .st_q      (st_q)
    );

    assign bp1_stored  = st_q.bp1;
    assign bp1_derived = st_q.cbpr ? bp_inc_sat(st_q.bp0) : st_q.bp1;

    vif_guest_read u_grd (
        .clk       (clk),
        .rst_n     (rst_n),
        .st        (st_q),
        .eff_bp1   (bp1_derived),
        .gst_addr  (gst_addr),
        .gst_rdata (gst_rdata)
    );

    // packed view: stored group 1 field, not the derived one
    always_ff @(posedge clk) begin
        if (!rst_n) hv_rdata <= pack_state(RST_STATE);
        else        hv_rdata <= pack_state(st_q);
    end

    always_comb begin
        prio_mask_o = st_q.pmask;
        eff_bp0_o   = st_q.bp0;
        eff_bp1_o   = bp1_derived;
        grp0_en_o   = st_q.en0;
        grp1_en_o   = st_q.en1;
        eoi_split_o = st_q.eoim;
        common_bp_o = st_q.cbpr;
    end

endmodule

// File: rtl/vif_ctrl_bank_chk.sv
module vif_ctrl_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hv_we,
    input logic [31:0] hv_wdata,
    input logic [31:0] hv_rdata,
    input logic [2:0]  gst_addr,
    input logic        gst_we,
    input logic [31:0] gst_wdata,
    input logic [7:0]  prio_mask_o,
    input logic [2:0]  eff_bp0_o,
    input logic [2:0]  eff_bp1_o,
    input logic        grp0_en_o,
    input logic        common_bp_o,
    input logic [2:0]  bp1_stored
);

    assert_bp0_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eff_bp0_o >= 3'd2);

    assert_bp1_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eff_bp1_o >= 3'd3);

    assert_packed_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hv_rdata[17:10] == 8'd0 && hv_rdata[8:5] == 4'd0 &&
        hv_rdata[2] == 1'b0 && hv_rdata[3] == 1'b1);

    assert_hyp_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hv_we |=> prio_mask_o == $past(hv_wdata[31:24]));

    assert_bp1_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (common_bp_o && gst_we && !hv_we && gst_addr == 3'd2) |=> $stable(bp1_stored));

    assert_bp_indep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!common_bp_o && gst_we && !hv_we && gst_addr == 3'd1) |=> $stable(eff_bp1_o));

    assert_guest_en0_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (gst_we && !hv_we && gst_addr == 3'd4) |=> grp0_en_o == $past(gst_wdata[0]));

endmodule

bind vif_ctrl_bank vif_ctrl_bank_chk u_chk (.*);

// File: tb/tb_vif_ctrl_bank.sv
`timescale 1ns/1ps
module tb_vif_ctrl_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hv_we = 1'b0;
    logic [31:0] hv_wdata = '0;
    logic [31:0] hv_rdata;
    logic [2:0]  gst_addr = '0;
    logic        gst_we = 1'b0;
    logic [31:0] gst_wdata = '0;
    logic [31:0] gst_rdata;
    logic [7:0]  prio_mask_o;
    logic [2:0]  eff_bp0_o, eff_bp1_o;
    logic        grp0_en_o, grp1_en_o, eoi_split_o, common_bp_o;

    vif_ctrl_bank dut (.*);

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // requirement model
    logic [7:0] m_pm;
    logic [2:0] m_b0, m_b1;
    logic       m_eo, m_cb, m_e1, m_e0;

    // scoreboard
    logic [31:0] exp_q[$];
    bit          view_q[$];
    string       req_q[$];
    bit          rd_v = 0, rd_view = 0;
    bit          rd_d = 0;

    function automatic logic [2:0] fl(input logic [2:0] v, input logic [2:0] lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic logic [2:0] b1_seen();
        if (m_cb) return (m_b0 == 3'd7) ? 3'd7 : m_b0 + 3'd1;
        return m_b1;
    endfunction

    function automatic logic [31:0] mpack();
        return {m_pm, m_b0, m_b1, 8'd0, m_eo, 4'd0, m_cb, 1'b1, 1'b0, m_e1, m_e0};
    endfunction

    function automatic logic [31:0] gexp(input logic [2:0] a);
        case (a)
            3'd0: return {24'd0, m_pm};
            3'd1: return {29'd0, m_b0};
            3'd2: return {29'd0, b1_seen()};
            3'd3: return {30'd0, m_cb, m_eo};
            3'd4: return {31'd0, m_e0};
            3'd5: return {31'd0, m_e1};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_hv(input logic [31:0] d);
        m_pm = d[31:24]; m_b0 = fl(d[23:21], 3'd2); m_b1 = fl(d[20:18], 3'd3);
        m_eo = d[9]; m_cb = d[4]; m_e1 = d[1]; m_e0 = d[0];
    endtask

    task automatic model_gst(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd0: m_pm = d[7:0];
            3'd1: m_b0 = fl(d[2:0], 3'd2);
            3'd2: if (!m_cb) m_b1 = fl(d[2:0], 3'd3);
            3'd3: begin m_eo = d[0]; m_cb = d[1]; end
            3'd4: m_e0 = d[0];
            3'd5: m_e1 = d[0];
            default: ;
        endcase
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        hv_we = 0; gst_we = 0; rd_v = 0;
    endtask

    task automatic hv_wr(input logic [31:0] d);
        @(negedge clk);
        hv_we = 1; hv_wdata = d; gst_we = 0; rd_v = 0;
        model_hv(d);
    endtask

    task automatic gst_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        hv_we = 0; gst_we = 1; gst_addr = a; gst_wdata = d; rd_v = 0;
        model_gst(a, d);
    endtask

    task automatic both_wr(input logic [31:0] hd, input logic [2:0] a, input logic [31:0] gd);
        @(negedge clk);
        hv_we = 1; hv_wdata = hd; gst_we = 1; gst_addr = a; gst_wdata = gd; rd_v = 0;
        model_hv(hd);
    endtask

    task automatic hv_rd(input string req);
        @(negedge clk);
        hv_we = 0; gst_we = 0; rd_v = 1; rd_view = 0;
        exp_q.push_back(mpack()); view_q.push_back(1'b0); req_q.push_back(req);
    endtask

    task automatic gst_rd(input logic [2:0] a, input string req);
        @(negedge clk);
        hv_we = 0; gst_we = 0; gst_addr = a; rd_v = 1; rd_view = 1;
        exp_q.push_back(gexp(a)); view_q.push_back(1'b1); req_q.push_back(req);
    endtask

    task automatic chk_outs(input string req);
        chk({req, " mask"},  {24'd0, prio_mask_o}, {24'd0, m_pm});
        chk({req, " bp0"},   {29'd0, eff_bp0_o},   {29'd0, m_b0});
        chk({req, " bp1"},   {29'd0, eff_bp1_o},   {29'd0, b1_seen()});
        chk({req, " modes"}, {28'd0, grp1_en_o, grp0_en_o, eoi_split_o, common_bp_o},
                             {28'd0, m_e1, m_e0, m_eo, m_cb});
    endtask

    // monitor: a read presented before edge k is compared after edge k
    always @(posedge clk) rd_d <= rd_v;

    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [31:0] e, a;
            bit v;
            string r;
            e = exp_q.pop_front(); v = view_q.pop_front(); r = req_q.pop_front();
            a = v ? gst_rdata : hv_rdata;
            chk(r, a, e);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_pm = 0; m_b0 = 3'd2; m_b1 = 3'd3; m_eo = 0; m_cb = 0; m_e1 = 0; m_e0 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values through both views and the outputs
        hv_rd("R1");
        chk("R1 reset word", 32'h004C_0008, mpack());
        for (int a = 0; a < 6; a++) gst_rd(3'(a), "R1");
        idle();
        chk_outs("R1");

        // R2/R3 packed layout, reserved bits and bit 3 ignored
        hv_wr(32'hA5B7_FFEE);
        hv_rd("R3");
        hv_rd("R2");
        for (int a = 0; a < 6; a++) gst_rd(3'(a), "R9");
        idle();
        chk_outs("R12");

        // R4/R5 floors from the packed view
        hv_wr(32'h3C04_0203);
        hv_rd("R4");
        gst_rd(3'd1, "R4");
        gst_rd(3'd2, "R5");

        // floors from the guest view
        gst_wr(3'd1, 32'h0000_0001);
        gst_rd(3'd1, "R4");
        gst_wr(3'd2, 32'h0000_0000);
        gst_rd(3'd2, "R5");

        // R6 guest map, R9 cross visibility, R12 outputs
        gst_wr(3'd0, 32'hFFFF_FF5A);
        gst_rd(3'd0, "R6");
        gst_wr(3'd4, 32'h1);
        gst_wr(3'd5, 32'h1);
        gst_wr(3'd3, 32'h1);
        hv_rd("R9");
        idle();
        chk_outs("R12");

        // R8 independent binary points
        gst_wr(3'd2, 32'h6);
        gst_wr(3'd1, 32'h4);
        idle();
        chk("R8 bp0", {29'd0, eff_bp0_o}, 32'd4);
        chk("R8 bp1", {29'd0, eff_bp1_o}, 32'd6);

        // R7 common binary point mode
        gst_wr(3'd3, 32'h2);
        gst_rd(3'd2, "R7");
        idle();
        chk("R7 derived", {29'd0, eff_bp1_o}, 32'd5);
        gst_wr(3'd1, 32'h7);
        gst_rd(3'd2, "R7");
        gst_wr(3'd2, 32'h3);
        hv_rd("R7");
        gst_wr(3'd3, 32'h0);
        gst_rd(3'd2, "R7");

        // R11 read right after a write shows the new value
        gst_wr(3'd0, 32'h33);
        gst_rd(3'd0, "R11");
        hv_rd("R11");

        // R10 simultaneous writes
        both_wr(32'h1100_0013, 3'd0, 32'h77);
        gst_rd(3'd0, "R10");
        hv_rd("R10");
        idle();
        chk_outs("R10");

        // R6 unmapped addresses
        gst_wr(3'd6, 32'hFFFF_FFFF);
        gst_rd(3'd6, "R6");
        gst_rd(3'd7, "R6");
        hv_rd("R6");
        idle();
        idle();
        idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule